// File: doc/BRIEF.md
# Address-Decoded Wait-State Generator

This block sits beside the memory bus of a 16-bit processor and decides, access by access, how long each bus cycle must be stretched. When the processor raises its access strobe, the block classifies the presented address into one of three regions. The low boot ROM region and a 256-byte fast RAM window are treated as zero-wait memory. Every other address is treated as slow memory and receives a fixed number of wait states. Each wait state holds the access for one clock period.

The block drives a ready line back to the processor. Ready low is the back-pressure signal: while it is low, the current access is held and the processor must keep its bus cycle open. When the wait count expires, ready returns high and the access completes on that cycle. A new strobe is accepted on any cycle, including one where ready is low, and it restarts the count for the new address. Read and write accesses are timed identically. Instruction fetches, operand reads and register reads to a slow workspace each raise their own strobe, so each one pays the penalty.

Two saturating running totals, one of accesses and one of clock cycles spent with ready low, let the whole-instruction time be checked as clock period × (base cycles + inserted wait cycles).

Top module: `wsg_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ready is 1, wait_cnt is 0 and both running totals are 0.
- R2: A strobe at any address from 0x0000 to 0x1FFF leaves ready at 1 and sets wait_cnt to 0 on the next cycle.
- R3: A strobe at any address from PAD_BASE (default 0x8300) to PAD_BASE+255 (default 0x83FF) leaves ready at 1 and sets wait_cnt to 0; addresses 0x82FF and 0x8400 are slow.
- R4: A strobe at any other address drives ready to 0 for exactly WAIT_STATES (default 4) consecutive cycles, starting on the cycle after the strobe, after which ready is 1.
- R5: The acc_write input has no effect on ready, wait_cnt or either total; a read and a write to the same address give the same timing.
- R6: A strobe arriving while ready is 0 restarts the count: for a slow address ready stays 0 for WAIT_STATES cycles after the new strobe; for a zero-wait address ready returns to 1 on the next cycle.
- R7: Strobes on consecutive cycles are each accepted and counted; none is lost.
- R8: wait_cnt shows, from the cycle after each strobe, the number of wait states assigned to that access (WAIT_STATES or 0), and holds it until the next strobe.
- R9: acc_total increases by 1 per strobe and wait_total by 1 per cycle in which ready is 0; both stop at their maximum value 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | Start of a memory access, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read; does not affect timing |
| acc_addr | input | ADDR_W (16) | Address of the access, sampled with the strobe |
| ready | output | 1 | 1 when the current access may complete; 0 holds the bus cycle |
| wait_cnt | output | $clog2(WAIT_STATES+1) (3) | Wait states assigned to the latest access |
| acc_total | output | CNT_W (16) | Saturating count of accesses |
| wait_total | output | CNT_W (16) | Saturating count of cycles with ready low |

## Verification
The hardest situation to reach is a strobe landing in the middle of a wait run, especially a zero-wait access cutting a slow one short, since a well-behaved processor would never issue it. The stimulus forces it with directed sequences that strike one and two cycles into a wait run, and the random phase raises strobes on about half of all cycles with addresses biased toward the region edges, so restarts at every stage of the count occur many times. The bench shrinks the total counters so that saturation is reached within the random phase.

// File: rtl/wsg_pkg.sv
`timescale 1ns/1ps
package wsg_pkg;
  typedef enum logic [1:0] {
    RGN_BOOT = 2'd0,
    RGN_FAST = 2'd1,
    RGN_SLOW = 2'd2
  } region_e;

  localparam int unsigned TALLY_N = 2;
  localparam int unsigned TALLY_ACC = 0;
  localparam int unsigned TALLY_WAIT = 1;
endpackage

// File: rtl/wsg_region_decode.sv
`timescale 1ns/1ps
module wsg_region_decode
  import wsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BOOT_TOP = 16'h1FFF,
  parameter int unsigned PAD_BASE = 16'h8300,
  parameter int unsigned PAD_SPAN = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_TOP);
  localparam logic [ADDR_W:0] PAD_LO   = (ADDR_W+1)'(PAD_BASE);
  localparam logic [ADDR_W:0] PAD_HI   = (ADDR_W+1)'(PAD_BASE + PAD_SPAN);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    if (a_ext <= BOOT_LIM)
      region = RGN_BOOT;
    else if (a_ext >= PAD_LO && a_ext < PAD_HI)
      region = RGN_FAST;
    else
      region = RGN_SLOW;
  end
endmodule

// File: rtl/wsg_wait_timer.sv
`timescale 1ns/1ps
module wsg_wait_timer #(
  parameter int unsigned WAIT_STATES = 4,
  localparam int unsigned WCW = $clog2(WAIT_STATES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           slow,
  output logic           ready,
  output logic [WCW-1:0] assigned
);
  localparam logic [WCW-1:0] LOAD = WCW'(WAIT_STATES);

  logic [WCW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain   <= '0;
      assigned <= '0;
    end else if (start) begin
      remain   <= slow ? LOAD : '0;
      assigned <= slow ? LOAD : '0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign ready = (remain == '0);
endmodule

// File: rtl/wsg_tally.sv
`timescale 1ns/1ps
module wsg_tally #(
  parameter int unsigned NUM   = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            bump,
  output logic [NUM-1:0][CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        count[g] <= '0;
      else if (bump[g] && count[g] != TOP)
        count[g] <= count[g] + 1'b1;
    end
  end
endmodule

// File: rtl/wsg_top.sv
`timescale 1ns/1ps
module wsg_top
  import wsg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BOOT_TOP    = 16'h1FFF,
  parameter int unsigned PAD_BASE    = 16'h8300,
  parameter int unsigned PAD_SPAN    = 256,
  parameter int unsigned WAIT_STATES = 4,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned WCW = $clog2(WAIT_STATES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ready,
  output logic [WCW-1:0]    wait_cnt,
  output logic [CNT_W-1:0]  acc_total,
  output logic [CNT_W-1:0]  wait_total
);
  region_e                         rgn;
  logic [TALLY_N-1:0]              bump;
  logic [TALLY_N-1:0][CNT_W-1:0]   totals;
  logic                            unused_write;

  // Direction of the access plays no part in its timing.
  assign unused_write = acc_write;

  wsg_region_decode #(
    .ADDR_W  (ADDR_W),
    .BOOT_TOP(BOOT_TOP),
    .PAD_BASE(PAD_BASE),
    .PAD_SPAN(PAD_SPAN)
  ) u_decode (
    .addr  (acc_addr),
    .region(rgn)
  );

  wsg_wait_timer #(
    .WAIT_STATES(WAIT_STATES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_strobe),
    .slow    (rgn == RGN_SLOW),
    .ready   (ready),
    .assigned(wait_cnt)
  );

  assign bump[TALLY_ACC]  = acc_strobe;
  assign bump[TALLY_WAIT] = !ready;

  wsg_tally #(
    .NUM  (TALLY_N),
    .CNT_W(CNT_W)
  ) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (bump),
    .count(totals)
  );

  assign acc_total  = totals[TALLY_ACC];
  assign wait_total = totals[TALLY_WAIT];
endmodule

// File: rtl/wsg_checker.sv
`timescale 1ns/1ps
module wsg_checker #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BOOT_TOP    = 16'h1FFF,
  parameter int unsigned PAD_BASE    = 16'h8300,
  parameter int unsigned PAD_SPAN    = 256,
  parameter int unsigned WAIT_STATES = 4,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned WCW = $clog2(WAIT_STATES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_strobe,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              ready,
  input logic [WCW-1:0]    wait_cnt,
  input logic [CNT_W-1:0]  acc_total,
  input logic [CNT_W-1:0]  wait_total
);
  logic in_boot, in_fast;
  assign in_boot = (32'(acc_addr) <= BOOT_TOP);
  assign in_fast = (32'(acc_addr) >= PAD_BASE) && (32'(acc_addr) < PAD_BASE + PAD_SPAN);

  p_boot_no_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && in_boot) |=> (ready && wait_cnt == '0));

  p_fast_no_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && in_fast) |=> (ready && wait_cnt == '0));

  p_slow_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && !in_boot && !in_fast) |=> (!ready && wait_cnt == WCW'(WAIT_STATES)));

  p_wait_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wait_total != '1) |=> (wait_total == $past(wait_total) + 1'b1));

  p_acc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_strobe && acc_total != '1) |=> (acc_total == $past(acc_total) + 1'b1));

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_strobe) |=> $stable(acc_total));

  p_wait_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_strobe) |=> $stable(wait_cnt));
endmodule

bind wsg_top wsg_checker #(
  .ADDR_W     (ADDR_W),
  .BOOT_TOP   (BOOT_TOP),
  .PAD_BASE   (PAD_BASE),
  .PAD_SPAN   (PAD_SPAN),
  .WAIT_STATES(WAIT_STATES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_strobe(acc_strobe),
  .acc_addr  (acc_addr),
  .ready     (ready),
  .wait_cnt  (wait_cnt),
  .acc_total (acc_total),
  .wait_total(wait_total)
);

// File: tb/tb_wsg_top.sv
`timescale 1ns/1ps
module tb_wsg_top;
  localparam int CNT_W = 10;
  localparam int WS    = 4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_strobe = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        ready;
  logic [2:0]  wait_cnt;
  logic [CNT_W-1:0] acc_total, wait_total;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int m_rem = 0;
  int m_asg = 0;
  int m_acc = 0;
  int m_wt  = 0;

  always #4 clk = ~clk;

  wsg_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_write(acc_write),
    .acc_addr(acc_addr), .ready(ready), .wait_cnt(wait_cnt),
    .acc_total(acc_total), .wait_total(wait_total)
  );

  function automatic int waits_for(input logic [15:0] a);
    if (a <= 16'h1FFF) return 0;
    if (a >= 16'h8300 && a <= 16'h83FF) return 0;
    return WS;
  endfunction

  function automatic int sat_inc(input int v);
    return (v >= int'(CMAX)) ? v : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem <= 0; m_asg <= 0; m_acc <= 0; m_wt <= 0;
    end else begin
      if (m_rem != 0) m_wt <= sat_inc(m_wt);
      if (acc_strobe) begin
        m_acc <= sat_inc(m_acc);
        m_rem <= waits_for(acc_addr);
        m_asg <= waits_for(acc_addr);
      end else if (m_rem != 0) begin
        m_rem <= m_rem - 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tag, int'(ready), (m_rem == 0) ? 1 : 0);
      check(rst_n ? "R8" : "R1", int'(wait_cnt), m_asg);
      check(rst_n ? "R9" : "R1", int'(acc_total), m_acc);
      check(rst_n ? "R9" : "R1", int'(wait_total), m_wt);
    end
  end

  task automatic step(input bit s, input bit w, input logic [15:0] a);
    @(negedge clk);
    #1;
    acc_strobe = s; acc_write = w; acc_addr = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0);
  endtask

  function automatic logic [15:0] pick_addr();
    int k = int'($urandom_range(0, 9));
    case (k)
      0: return 16'h1FFF;
      1: return 16'h2000;
      2: return 16'h82FF;
      3: return 16'h8300;
      4: return 16'h83FF;
      5: return 16'h8400;
      6: return 16'($urandom_range(0, 16'h1FFF));
      7: return 16'h8300 + 16'($urandom_range(0, 255));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1357));
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1", int'(ready), 1);
    check("R1", int'(acc_total), 0);

    tag = "R2";
    step(1, 0, 16'h0000); step(1, 1, 16'h1FFF); step(1, 0, 16'h0ABC); idle(2);
    tag = "R3";
    step(1, 0, 16'h8300); step(1, 1, 16'h83FF); idle(1);
    step(1, 0, 16'h82FF); idle(5);
    step(1, 0, 16'h8400); idle(5);
    tag = "R4";
    step(1, 0, 16'h2000); idle(6);
    step(1, 0, 16'hFFFF); idle(6);
    tag = "R5";
    step(1, 0, 16'hA000); idle(5);
    step(1, 1, 16'hA000); idle(5);
    tag = "R6";
    step(1, 0, 16'h4000); idle(2); step(1, 0, 16'h4002); idle(6);
    step(1, 1, 16'h6000); idle(1); step(1, 0, 16'h8310); idle(3);
    step(1, 0, 16'h6000); step(1, 0, 16'h0100); idle(2);
    tag = "R7";
    for (int i = 0; i < 5; i++) step(1, 0, 16'h9000 + 16'(2*i));
    step(1, 0, 16'h0002); step(1, 0, 16'hC000); step(1, 0, 16'h83FE);
    idle(6);

    tag = "R4";
    for (int i = 0; i < 4000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick_addr());
    idle(6);

    @(negedge clk);
    #2;
    check("R9", int'(acc_total), int'(CMAX));
    check("R9", int'(wait_total), int'(CMAX));
    check("R4", int'(ready), 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule